// File: doc/BRIEF.md
# Command Ring Transmit Engine

This block walks a circular ring of 32-bit codec commands held in memory and passes them, one at a time, to a link transmitter. Software places commands in the ring, then writes a last-valid index. The engine fetches each entry after its read pointer and hands it downstream. It stops right after sending the entry named by that last-valid index, and it moves on only when software writes a new index.

The ring can hold 2, 16 or 256 entries, selected by a size code. The read pointer wraps from the last entry back to entry zero. A run level starts and stops the engine. When the run level drops, any entry already being fetched or sent is finished first, and only then does the engine report itself stopped.

A separate immediate command port sends one command around the ring. It is only accepted while the engine is stopped. A write to it while the engine is running is refused and raises a sticky error flag.

Top module: `cmd_ring_dma`

## Requirements
- R1: After reset, the read pointer is 0, the last-valid index is 0, and tx_valid_o, mem_req_o, running_o and imm_err_o are all low.
- R2: Ring entries are fetched from address base_i + 4*index. mem_req_o stays high until mem_rvalid_i returns the word, and the word is then presented on tx_data_o.
- R3: The read pointer holds the index of the last entry sent. While running, the engine sends the entries after it in ring order up to and including the last-valid index, then stops with the read pointer equal to it. It issues no fetch while the two are equal.
- R4: The size code sets the ring depth: 0 gives 2 entries, 1 gives 16, 2 gives 256, and 3 is treated as 2. The entry after index depth-1 is index 0.
- R5: After the engine has stopped at the last-valid index, writing a new last-valid index resumes transmission from the entry after the read pointer.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o holds its value. Each ring entry is sent exactly once, and the read pointer advances only on the handshake.
- R7: When run_i goes low, an entry already being fetched or sent is completed. running_o stays high until that completes, then goes low, and no further fetch is made.
- R8: A pulse on swrst_i sets the read pointer to 0 when running_o is low. While running_o is high it has no effect.
- R9: An immediate write made while running_o is low and no immediate command is waiting is sent on tx_data_o. It does not change the read pointer, and the ring never drives tx_valid_o at the same time.
- R10: An immediate write made while running_o is high is not sent and sets imm_err_o, which stays set until a pulse on imm_err_clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run level for the ring engine |
| swrst_i | input | 1 | Read-pointer reset pulse, honoured only while stopped |
| size_sel_i | input | 2 | Ring depth code |
| base_i | input | ADDR_W | Byte address of ring entry 0 |
| wp_wr_i | input | 1 | Write strobe for the last-valid index |
| wp_data_i | input | 8 | New last-valid index |
| rp_o | output | 8 | Read pointer: index of the last entry sent |
| running_o | output | 1 | Engine active or still draining |
| mem_req_o | output | 1 | Memory read request, held until the response |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | CMD_W | Memory read data |
| tx_valid_o | output | 1 | Command valid toward the link |
| tx_data_o | output | CMD_W | Command word |
| tx_ready_i | input | 1 | Link accepts the command |
| imm_wr_i | input | 1 | Immediate command write strobe |
| imm_data_i | input | CMD_W | Immediate command word |
| imm_err_clr_i | input | 1 | Clears the immediate error flag |
| imm_err_o | output | 1 | Sticky flag for a refused immediate write |

## Verification
The assertions assume that memory answers a request only while mem_req_o is high, with a single mem_rvalid_i pulse that comes at least one cycle after the request. They also assume that size_sel_i and base_i do not change while the engine is busy. The bench's memory model answers every request once, after two cycles, and lowers its valid line in the next cycle. The bench changes the size and base only after the queue of expected words has drained and the engine has gone idle. The read-pointer reset is pulsed both while stopped and while running, so that the "no effect" case can be seen at rp_o.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  localparam int PTR_W = 8;

  typedef enum logic [1:0] {
    RING_2    = 2'd0,
    RING_16   = 2'd1,
    RING_256  = 2'd2,
    RING_RSVD = 2'd3
  } ring_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2
  } eng_state_e;

  function automatic logic [PTR_W-1:0] last_index(input logic [1:0] sz);
    logic [PTR_W-1:0] r;
    case (ring_size_e'(sz))
      RING_16:  r = PTR_W'(15);
      RING_256: r = PTR_W'(255);
      default:  r = PTR_W'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmd_ring_ptr.sv
module cmd_ring_ptr
  import cmd_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size_sel_i,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [PTR_W-1:0] rp_o,
  output logic [PTR_W-1:0] nxt_o
);

  logic [PTR_W-1:0] rp_q, rp_d;
  logic [PTR_W-1:0] lim;
  logic             rp_en;

  assign lim   = last_index(size_sel_i);
  assign nxt_o = (rp_q >= lim) ? '0 : rp_q + 1'b1;
  assign rp_en = adv_i | clr_i;

  always_comb begin
    rp_d = rp_q;
    if (clr_i)      rp_d = '0;
    else if (adv_i) rp_d = nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rp_q <= '0;
    else if (rp_en) rp_q <= rp_d;
  end

  assign rp_o = rp_q;

endmodule

// File: rtl/cmd_ring_fsm.sv
module cmd_ring_fsm
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              blocked_i,
  input  logic [PTR_W-1:0]  rp_i,
  input  logic [PTR_W-1:0]  nxt_i,
  input  logic [PTR_W-1:0]  wp_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              mem_rvalid_i,
  input  logic [CMD_W-1:0]  mem_rdata_i,
  input  logic              tx_ready_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              ring_valid_o,
  output logic [CMD_W-1:0]  ring_data_o,
  output logic              adv_o,
  output logic              busy_o
);

  localparam int PAD_W = ADDR_W - PTR_W - 2;

  eng_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CMD_W-1:0]  data_q;
  logic              addr_en, data_en;
  logic              start;

  assign start   = run_i && !blocked_i && (rp_i != wp_i);
  assign addr_d  = base_i + {{PAD_W{1'b0}}, nxt_i, 2'b00};
  assign addr_en = (st_q == ST_IDLE) && start;
  assign data_en = (st_q == ST_FETCH) && mem_rvalid_i;

  always_comb begin
    st_d  = st_q;
    adv_o = 1'b0;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_FETCH;
      ST_FETCH: if (mem_rvalid_i) st_d = ST_SEND;
      ST_SEND: begin
        if (tx_ready_i) begin
          st_d  = ST_IDLE;
          adv_o = 1'b1;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mem_rdata_i;
  end

  assign mem_req_o    = (st_q == ST_FETCH);
  assign mem_addr_o   = addr_q;
  assign ring_valid_o = (st_q == ST_SEND);
  assign ring_data_o  = data_q;
  assign busy_o       = (st_q != ST_IDLE);

endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_wr_i,
  input  logic [PTR_W-1:0] wp_data_i,
  input  logic             imm_wr_i,
  input  logic [CMD_W-1:0] imm_data_i,
  input  logic             err_clr_i,
  input  logic             running_i,
  input  logic             tx_ready_i,
  output logic [PTR_W-1:0] wp_o,
  output logic             imm_valid_o,
  output logic [CMD_W-1:0] imm_data_o,
  output logic             err_o
);

  logic [PTR_W-1:0] wp_q;
  logic             pend_q, pend_d;
  logic [CMD_W-1:0] idat_q;
  logic             err_q, err_d;
  logic             accept, reject;

  assign accept = imm_wr_i && !running_i && !pend_q;
  assign reject = imm_wr_i && !accept;

  always_comb begin
    pend_d = pend_q;
    if (pend_q && tx_ready_i) pend_d = 1'b0;
    if (accept)               pend_d = 1'b1;
  end

  always_comb begin
    err_d = err_q;
    if (err_clr_i) err_d = 1'b0;
    if (reject)    err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wp_q <= '0;
    else if (wp_wr_i) wp_q <= wp_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idat_q <= '0;
    else if (accept) idat_q <= imm_data_i;
  end

  assign wp_o        = wp_q;
  assign imm_valid_o = pend_q;
  assign imm_data_o  = idat_q;
  assign err_o       = err_q;

endmodule

// File: rtl/cmd_ring_dma.sv
module cmd_ring_dma
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              swrst_i,
  input  logic [1:0]        size_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wp_wr_i,
  input  logic [PTR_W-1:0]  wp_data_i,
  output logic [PTR_W-1:0]  rp_o,
  output logic              running_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [CMD_W-1:0]  mem_rdata_i,
  output logic              tx_valid_o,
  output logic [CMD_W-1:0]  tx_data_o,
  input  logic              tx_ready_i,
  input  logic              imm_wr_i,
  input  logic [CMD_W-1:0]  imm_data_i,
  input  logic              imm_err_clr_i,
  output logic              imm_err_o
);

  logic [PTR_W-1:0] nxt_idx, wp_q;
  logic             ptr_adv, ptr_clr;
  logic             eng_busy;
  logic             ring_valid, imm_valid;
  logic [CMD_W-1:0] ring_data, imm_data;

  assign running_o = run_i | eng_busy;
  assign ptr_clr   = swrst_i & ~running_o;

  cmd_ring_ptr u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_sel_i (size_sel_i),
    .adv_i      (ptr_adv),
    .clr_i      (ptr_clr),
    .rp_o       (rp_o),
    .nxt_o      (nxt_idx)
  );

  cmd_ring_fsm #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .blocked_i    (imm_valid),
    .rp_i         (rp_o),
    .nxt_i        (nxt_idx),
    .wp_i         (wp_q),
    .base_i       (base_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .tx_ready_i   (tx_ready_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .ring_valid_o (ring_valid),
    .ring_data_o  (ring_data),
    .adv_o        (ptr_adv),
    .busy_o       (eng_busy)
  );

  cmd_ring_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_wr_i     (wp_wr_i),
    .wp_data_i   (wp_data_i),
    .imm_wr_i    (imm_wr_i),
    .imm_data_i  (imm_data_i),
    .err_clr_i   (imm_err_clr_i),
    .running_i   (running_o),
    .tx_ready_i  (tx_ready_i),
    .wp_o        (wp_q),
    .imm_valid_o (imm_valid),
    .imm_data_o  (imm_data),
    .err_o       (imm_err_o)
  );

  assign tx_valid_o = ring_valid | imm_valid;
  assign tx_data_o  = ring_valid ? ring_data : imm_data;

endmodule

// File: rtl/cmd_ring_sva.sv
module cmd_ring_sva
  import cmd_ring_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             swrst,
  input logic [PTR_W-1:0] rp,
  input logic [PTR_W-1:0] wp,
  input logic             ring_valid,
  input logic             imm_valid,
  input logic             busy,
  input logic             running,
  input logic             mem_req,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [CMD_W-1:0] tx_data,
  input logic             imm_wr,
  input logic             err
);

  // R9: ring and immediate path never drive the link together
  assert_path_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_valid && imm_valid));

  // R6: a stalled command is held unchanged
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R3: the read pointer moves only on a ring handshake or an honoured reset
  assert_rp_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ring_valid && tx_ready) && !(swrst && !running)) |=> $stable(rp));

  // R3: a fetch starts only when entries are outstanding
  assert_no_idle_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(rp != wp));

  // R7: once stopped and drained, no fetch follows
  assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !busy) |=> !mem_req);

  // R10: a refused immediate write raises the error flag
  assert_imm_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_wr && running) |=> err);

endmodule

bind cmd_ring_dma cmd_ring_sva #(.CMD_W(CMD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_i),
  .swrst      (swrst_i),
  .rp         (rp_o),
  .wp         (wp_q),
  .ring_valid (ring_valid),
  .imm_valid  (imm_valid),
  .busy       (eng_busy),
  .running    (running_o),
  .mem_req    (mem_req_o),
  .tx_valid   (tx_valid_o),
  .tx_ready   (tx_ready_i),
  .tx_data    (tx_data_o),
  .imm_wr     (imm_wr_i),
  .err        (imm_err_o)
);

// File: tb/tb_cmd_ring_dma.sv
`timescale 1ns/1ps
module tb_cmd_ring_dma;

  localparam int AW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_i = 1'b0, swrst_i = 1'b0, wp_wr_i = 1'b0;
  logic [1:0]    size_sel_i = 2'd1;
  logic [AW-1:0] base_i = 32'h0000_1000;
  logic [7:0]    wp_data_i = '0;
  logic [7:0]    rp_o;
  logic          running_o, mem_req_o, tx_valid_o, imm_err_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rvalid_i = 1'b0;
  logic [CW-1:0] mem_rdata_i = '0;
  logic [CW-1:0] tx_data_o;
  logic          tx_ready_i;
  logic          imm_wr_i = 1'b0, imm_err_clr_i = 1'b0;
  logic [CW-1:0] imm_data_i = '0;

  int errors = 0, checks = 0, cyc = 0, lat = 2;
  int exp_rp = 0;
  logic [CW-1:0] expq[$];
  logic rdy_rand = 1'b1, rdy_force = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_hold = 1'b0;
  logic [CW-1:0] prev_data = '0;

  always #4 clk = ~clk;

  cmd_ring_dma #(.ADDR_W(AW), .CMD_W(CW)) dut (.*);

  assign tx_ready_i = rdy_rand ? lfsr[0] : rdy_force;

  function automatic logic [CW-1:0] word_at(logic [AW-1:0] a);
    return 32'h5A00_0000 | {8'h00, a[23:0]};
  endfunction

  function automatic int depth_of(logic [1:0] s);
    return (s == 2'd1) ? 16 : (s == 2'd2) ? 256 : 2;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cyc  <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // memory model: answers each request after two cycles with one pulse
  always @(negedge clk) begin
    if (mem_rvalid_i) mem_rvalid_i = 1'b0;
    else if (mem_req_o) begin
      if (lat == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = word_at(mem_addr_o);
        lat = 2;
      end else lat--;
    end
  end

  // monitor: scoreboard compare and hold check (R2, R6, R9)
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      if (prev_hold)
        check(tx_valid_o && tx_data_o == prev_data, "R6 hold", tx_data_o, prev_data);
      if (tx_valid_o && tx_ready_i) begin
        if (expq.size() == 0)
          check(1'b0, "R6 unexpected word", tx_data_o, 32'h0);
        else begin
          logic [CW-1:0] e;
          e = expq.pop_front();
          check(tx_data_o == e, "R2 word", tx_data_o, e);
        end
      end
      prev_hold = tx_valid_o && !tx_ready_i;
      prev_data = tx_data_o;
    end
  end

  task automatic push_to(input int new_wp);
    int d = depth_of(size_sel_i);
    int i = exp_rp;
    while (i != new_wp) begin
      i = (i + 1) % d;
      expq.push_back(word_at(base_i + AW'(i * 4)));
    end
    exp_rp = new_wp;
  endtask

  task automatic write_wp(input int v);
    @(negedge clk); wp_wr_i = 1'b1; wp_data_i = 8'(v);
    @(negedge clk); wp_wr_i = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!(expq.size() == 0 && !tx_valid_o && !mem_req_o));
    repeat (2) @(negedge clk);
  endtask

  task automatic send_to(input int v, input string tag);
    push_to(v);
    write_wp(v);
    drain();
    check(rp_o == 8'(v), tag, rp_o, v);
  endtask

  task automatic quiet(input string tag);
    logic seen = 1'b0;
    repeat (10) begin @(negedge clk); seen |= mem_req_o | tx_valid_o; end
    check(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rp_o == 0 && !tx_valid_o && !mem_req_o && !running_o && !imm_err_o,
          "R1 reset state", {rp_o, 3'b0, tx_valid_o, mem_req_o, running_o, imm_err_o}, 0);

    run_i = 1'b1;
    quiet("R3 no fetch when equal");
    send_to(3, "R3 stop at last valid");
    quiet("R3 idle after stop");
    send_to(5, "R5 resume on new index");
    send_to(1, "R4 wrap depth 16");
    size_sel_i = 2'd0;
    send_to(0, "R4 wrap depth 2");
    size_sel_i = 2'd3;
    send_to(1, "R4 code 3 as depth 2");

    @(negedge clk); swrst_i = 1'b1;
    @(negedge clk); swrst_i = 1'b0;
    check(rp_o == 1, "R8 reset ignored while running", rp_o, 1);

    run_i = 1'b0;
    @(negedge clk);
    check(!running_o, "R7 stopped when idle", running_o, 0);
    @(negedge clk); swrst_i = 1'b1;
    @(negedge clk); swrst_i = 1'b0;
    exp_rp = 0;
    check(rp_o == 0, "R8 reset while stopped", rp_o, 0);

    size_sel_i = 2'd2; base_i = 32'h0040_0100; run_i = 1'b1;
    send_to(255, "R3 long ring");
    send_to(0, "R4 wrap depth 256");

    // R7: drop run during a stalled send
    rdy_rand = 1'b0; rdy_force = 1'b0;
    expq.push_back(word_at(base_i + 32'd4));
    write_wp(4);
    do @(negedge clk); while (!tx_valid_o);
    run_i = 1'b0;
    repeat (3) @(negedge clk);
    check(running_o, "R7 running while draining", running_o, 1);
    rdy_force = 1'b1;
    drain();
    check(!running_o && rp_o == 1, "R7 stopped after in-flight", {running_o, rp_o}, 1);
    quiet("R7 no fetch after stop");
    run_i = 1'b1; rdy_rand = 1'b1;
    exp_rp = 1;
    push_to(4);
    drain();
    check(rp_o == 4, "R5 remainder after restart", rp_o, 4);

    // R9: immediate command while stopped
    run_i = 1'b0;
    repeat (2) @(negedge clk);
    expq.push_back(32'h0F00_1234);
    imm_data_i = 32'h0F00_1234; imm_wr_i = 1'b1;
    @(negedge clk); imm_wr_i = 1'b0;
    drain();
    check(rp_o == 4 && !imm_err_o, "R9 pointer unchanged", rp_o, 4);

    // R10: immediate command while running
    run_i = 1'b1;
    @(negedge clk); imm_data_i = 32'h1111_2222; imm_wr_i = 1'b1;
    @(negedge clk); imm_wr_i = 1'b0; #1;
    check(imm_err_o, "R10 error set", imm_err_o, 1);
    quiet("R10 refused word not sent");
    check(imm_err_o, "R10 error sticky", imm_err_o, 1);
    @(negedge clk); imm_err_clr_i = 1'b1;
    @(negedge clk); imm_err_clr_i = 1'b0; #1;
    check(!imm_err_o, "R10 error cleared", imm_err_o, 0);

    check(expq.size() == 0, "R6 all words delivered", expq.size(), 0);
    summary();
    $finish;
  end

endmodule